// File: doc/BRIEF.md
# Latched and Level Interrupt Controller

This block decides when a small single-issue processor core may enter an interrupt handler and which handler it should enter. It serves two kinds of sources. Event sources set a sticky flag on a one-cycle pulse, and the flag stays set until it is serviced or cleared by software. Level sources have no flag and request service only while their input is high. Each source has its own enable bit, and a global enable gates all of them. Software reaches the flags, the enables and a read-only view of the global enable through a small register port.

The core sends the block strobes for instruction retire, return-from-interrupt, global enable and global disable. The block returns a take-interrupt request together with a vector number. When the core acknowledges a request, the block drops the global enable and clears the flag of the serviced source. The status register is not saved or restored here; software does that.

Entry is run by a three-state machine. **MASKED** is the state after reset and after an entry, with the global enable clear. **HOLDOFF** means the global enable is set but one more instruction must retire first. **ARMED** means a request may be taken. The transitions are:
- **MASKED→HOLDOFF** on a return or global-enable strobe.
- **HOLDOFF→ARMED** on a retire strobe, provided no return or global-enable strobe comes in the same cycle.
- **ARMED→MASKED** on an acknowledged take.
- **ARMED→HOLDOFF** on a return or global-enable strobe.
- **any→MASKED** on a global-disable strobe. This has the highest priority.

Top module: `irqc_top`

## Requirements
- R1: An event pulse sets its source's flag on the next clock edge whatever that source's enable bit is. The flag is visible in register 0, where bit i is event source i.
- R2: Flags set while the global enable is clear stay pending. Once the enable path is armed, they are taken one per acknowledge.
- R3: A write to register 0 clears each flag whose data bit is one. Zero bits leave their flags unchanged. An event pulse in the same cycle as the clear wins.
- R4: An acknowledged take clears the serviced event flag on the same edge. An event pulse on that source in the same cycle keeps the flag set.
- R5: A level source requests only while its input is high and its enable bit is set. Once the input drops, nothing is remembered.
- R6: Priority is fixed and the lowest source index wins. Event sources are indices 0..N_FLAG-1 and level sources follow them. The vector equals the winner's index plus one, and 0 means that no source requests.
- R7: An acknowledge taken while the take request is high clears the global enable. A return strobe sets the global enable again, but entry waits until one retire strobe has come.
- R8: After a global-enable strobe, the take request stays low until one retire strobe has come.
- R9: A global-disable strobe forces the take request low in its own cycle, even for a request that rises in that same cycle, and clears the global enable on the next edge. It overrides a global-enable strobe in the same cycle.
- R10: Register 1 holds the enable bits, read and write, with bit i as source i. Register 2 bit 0 reads the global enable. Reads are combinational.
- R11: After reset, the flags, the enables and the global enable are all zero, and the take request is low.
- R12: An acknowledge while the take request is low has no effect on the flags or on the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | N_FLAG | One-cycle event pulses, one bit per flagged source |
| lvl_i | input | N_LEVEL | Level request inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 enables, 2 global enable |
| reg_wdata_i | input | N_FLAG+N_LEVEL | Write data |
| reg_rdata_o | output | N_FLAG+N_LEVEL | Combinational read data |
| retire_i | input | 1 | An instruction retired this cycle |
| reti_i | input | 1 | Return-from-interrupt strobe |
| sei_i | input | 1 | Global-enable strobe |
| cli_i | input | 1 | Global-disable strobe |
| ack_i | input | 1 | Core accepts the current take request |
| irq_o | output | 1 | Take-interrupt request |
| vec_o | output | $clog2(N_FLAG+N_LEVEL+1) | Vector number of the highest-priority requester |
| gie_o | output | 1 | Global enable state |

## Verification
The take request, the vector and the read data are combinational. They are due in the same cycle as the inputs that cause them. A flag, an enable or a change of the global enable takes one clock edge to appear. Entry after a global-enable or return strobe is due no earlier than two edges later: one edge to reach HOLDOFF and one retire edge to reach ARMED. The bench drives every row on the falling edge and samples 1 ns later, before the next rising edge. Each expectation is written against the state left by the earlier rows.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ST_MASKED  = 2'd0,
        ST_HOLDOFF = 2'd1,
        ST_ARMED   = 2'd2
    } entry_state_t;

    localparam logic [1:0] ADDR_FLAG = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_GIE  = 2'd2;

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int N_FLAG = 4,
    parameter int N_SRC  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] evt_i,
    input  logic              w1c_i,
    input  logic [N_FLAG-1:0] w1c_mask_i,
    input  logic              en_wr_i,
    input  logic [N_SRC-1:0]  en_wdata_i,
    input  logic [N_FLAG-1:0] ack_clr_i,
    output logic [N_FLAG-1:0] flag_o,
    output logic [N_SRC-1:0]  en_o
);

    logic [N_FLAG-1:0] flag_q;
    logic [N_FLAG-1:0] flag_d;
    logic [N_FLAG-1:0] sw_clr;
    logic [N_SRC-1:0]  en_q;

    // set dominates both clear paths
    always_comb begin
        sw_clr = w1c_i ? w1c_mask_i : '0;
        flag_d = (flag_q & ~sw_clr & ~ack_clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= en_wdata_i;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R1

    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_clr_i != '0) && ((ack_clr_i & evt_i) == '0))
        |=> ((flag_q & $past(ack_clr_i)) == '0)); // R4

    AST_W0_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && (w1c_mask_i == '0) && (ack_clr_i == '0))
        |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R3

endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int N_SRC = 6,
    parameter int VEC_W = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] grant_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             any_o
);

    always_comb begin
        grant_o = '0;
        vec_o   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                vec_o      = VEC_W'(i + 1);
            end
        end
        any_o = |req_i;
    end

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R6
        AST_VEC_RANGE: assert (vec_o <= VEC_W'(N_SRC)); // R6
    end

endmodule

// File: rtl/irqc_entry_fsm.sv
module irqc_entry_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic retire_i,
    input  logic reti_i,
    input  logic sei_i,
    input  logic cli_i,
    input  logic ack_i,
    input  logic any_req_i,
    output logic irq_o,
    output logic gie_o,
    output logic take_o
);

    entry_state_t state_q;
    entry_state_t state_d;
    logic         rearm;

    assign rearm = reti_i | sei_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MASKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASKED: begin
                if (rearm) state_d = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (rearm)         state_d = ST_HOLDOFF;
                else if (retire_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (take_o)     state_d = ST_MASKED;
                else if (rearm) state_d = ST_HOLDOFF;
            end
            default: state_d = ST_MASKED;
        endcase
        if (cli_i) state_d = ST_MASKED;
    end

    always_comb begin
        gie_o  = (state_q != ST_MASKED);
        irq_o  = (state_q == ST_ARMED) && any_req_i && !cli_i;
        take_o = irq_o && ack_i;
    end

    AST_CLI_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        cli_i |=> !gie_o); // R9

    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !gie_o); // R7

    AST_NO_ENTRY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie_o) |-> !irq_o); // R8

    AST_RETI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !cli_i) |=> (gie_o && !irq_o)); // R7

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_FLAG  = 4,
    parameter int N_LEVEL = 2,
    parameter int N_SRC   = N_FLAG + N_LEVEL,
    parameter int VEC_W   = $clog2(N_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAG-1:0]  evt_i,
    input  logic [N_LEVEL-1:0] lvl_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [N_SRC-1:0]   reg_wdata_i,
    output logic [N_SRC-1:0]   reg_rdata_o,
    input  logic               retire_i,
    input  logic               reti_i,
    input  logic               sei_i,
    input  logic               cli_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               gie_o
);

    logic [N_FLAG-1:0] flag;
    logic [N_SRC-1:0]  en;
    logic [N_SRC-1:0]  req;
    logic [N_SRC-1:0]  grant;
    logic [N_FLAG-1:0] ack_clr;
    logic              any_req;
    logic              take;
    logic              w1c;
    logic              en_wr;

    assign w1c   = reg_wr_i && (reg_addr_i == ADDR_FLAG);
    assign en_wr = reg_wr_i && (reg_addr_i == ADDR_EN);

    irqc_flag_bank #(
        .N_FLAG (N_FLAG),
        .N_SRC  (N_SRC)
    ) flag_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .w1c_i      (w1c),
        .w1c_mask_i (reg_wdata_i[N_FLAG-1:0]),
        .en_wr_i    (en_wr),
        .en_wdata_i (reg_wdata_i),
        .ack_clr_i  (ack_clr),
        .flag_o     (flag),
        .en_o       (en)
    );

    // flagged sources first, level sources above them
    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_req
            if (g < N_FLAG) begin : g_evt
                assign req[g] = flag[g] & en[g];
            end else begin : g_lvl
                assign req[g] = lvl_i[g-N_FLAG] & en[g];
            end
        end
    endgenerate

    irqc_prio_pick #(
        .N_SRC (N_SRC),
        .VEC_W (VEC_W)
    ) prio_pick_i (
        .req_i   (req),
        .grant_o (grant),
        .vec_o   (vec_o),
        .any_o   (any_req)
    );

    irqc_entry_fsm entry_fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .reti_i    (reti_i),
        .sei_i     (sei_i),
        .cli_i     (cli_i),
        .ack_i     (ack_i),
        .any_req_i (any_req),
        .irq_o     (irq_o),
        .gie_o     (gie_o),
        .take_o    (take)
    );

    assign ack_clr = take ? grant[N_FLAG-1:0] : '0;

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_FLAG: reg_rdata_o[N_FLAG-1:0] = flag;
            ADDR_EN:   reg_rdata_o = en;
            ADDR_GIE:  reg_rdata_o[0] = gie_o;
            default:   reg_rdata_o = '0;
        endcase
    end

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_o && (vec_o != '0))); // R6

    AST_IDLE_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !reti_i && !sei_i && !cli_i)
        |=> (gie_o == $past(gie_o))); // R12

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    localparam int NF = 4;
    localparam int NL = 2;
    localparam int NS = NF + NL;
    localparam int VW = $clog2(NS + 1);
    localparam int NROWS = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] evt_i = '0;
    logic [NL-1:0] lvl_i = '0;
    logic          reg_wr_i = 1'b0;
    logic [1:0]    reg_addr_i = '0;
    logic [NS-1:0] reg_wdata_i = '0;
    logic [NS-1:0] reg_rdata_o;
    logic          retire_i = 1'b0;
    logic          reti_i = 1'b0;
    logic          sei_i = 1'b0;
    logic          cli_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          irq_o;
    logic [VW-1:0] vec_o;
    logic          gie_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqc_top #(.N_FLAG(NF), .N_LEVEL(NL)) dut_i (
        .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .lvl_i (lvl_i),
        .reg_wr_i (reg_wr_i), .reg_addr_i (reg_addr_i),
        .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o),
        .retire_i (retire_i), .reti_i (reti_i), .sei_i (sei_i),
        .cli_i (cli_i), .ack_i (ack_i), .irq_o (irq_o),
        .vec_o (vec_o), .gie_o (gie_o)
    );

    // row: tag evt lvl ret reti sei cli ack wr addr wdata | irq vec gie rdata
    function automatic logic [35:0] mk(input int tg, input int ev, input int lv,
        input int rt, input int ri, input int se, input int cl, input int ak,
        input int wr, input int ad, input int wd,
        input int xi, input int xv, input int xg, input int xr);
        logic [35:0] r;
        r = '0;
        r[35:32] = 4'(tg); r[31:28] = 4'(ev); r[27:26] = 2'(lv);
        r[25] = 1'(rt); r[24] = 1'(ri); r[23] = 1'(se); r[22] = 1'(cl);
        r[21] = 1'(ak); r[20] = 1'(wr); r[19:18] = 2'(ad); r[17:12] = 6'(wd);
        r[11] = 1'(xi); r[10:8] = 3'(xv); r[7] = 1'(xg); r[6:1] = 6'(xr);
        return r;
    endfunction

    localparam logic [35:0] TBL [NROWS] = '{
        mk(11,0,0, 0,0,0,0,0, 0,0,0,  0,0,0,0),   // R11 idle after reset
        mk(1, 4,0, 0,0,0,0,0, 0,0,0,  0,0,0,0),   // R1 event, enable clear
        mk(1, 0,0, 0,0,0,0,0, 0,0,0,  0,0,0,4),   // R1 flag latched
        mk(10,0,0, 0,0,0,0,0, 1,1,63, 0,0,0,0),   // R10 write enables
        mk(2, 0,0, 0,0,0,0,0, 0,1,0,  0,3,0,63),  // R2 pending, masked
        mk(2, 1,0, 0,0,0,0,0, 0,0,0,  0,3,0,4),   // R2 second event
        mk(6, 0,0, 0,0,1,0,0, 0,0,0,  0,1,0,5),   // R6 lowest wins
        mk(8, 0,0, 0,0,0,0,0, 0,0,0,  0,1,1,5),   // R8 holdoff
        mk(8, 0,0, 1,0,0,0,0, 0,0,0,  0,1,1,5),   // R8 retire
        mk(2, 0,0, 0,0,0,0,1, 0,0,0,  1,1,1,5),   // R2 take src0
        mk(7, 0,0, 0,0,0,0,1, 0,0,0,  0,3,0,4),   // R7 gie cleared; idle ack
        mk(12,0,0, 0,1,0,0,0, 0,0,0,  0,3,0,4),   // R12 idle ack kept flag
        mk(7, 0,0, 0,0,0,0,0, 0,0,0,  0,3,1,4),   // R7 return holdoff
        mk(7, 0,0, 1,0,0,0,0, 0,0,0,  0,3,1,4),   // R7 retire
        mk(4, 4,0, 0,0,0,0,1, 0,0,0,  1,3,1,4),   // R4 take with new event
        mk(4, 0,0, 0,0,0,0,0, 0,0,0,  0,3,0,4),   // R4 set wins over ack
        mk(3, 0,0, 0,0,0,0,0, 1,0,4,  0,3,0,4),   // R3 write-one clear
        mk(3, 8,0, 0,0,0,0,0, 0,0,0,  0,0,0,0),   // R3 cleared
        mk(3, 0,0, 0,0,0,0,0, 1,0,0,  0,4,0,8),   // R3 write zero
        mk(3, 0,0, 0,0,0,0,0, 0,0,0,  0,4,0,8),   // R3 unchanged
        mk(3, 0,0, 0,0,0,0,0, 1,0,8,  0,4,0,8),   // R3 clear src3
        mk(3, 0,0, 0,0,0,0,0, 0,0,0,  0,0,0,0),   // R3 cleared
        mk(5, 0,1, 0,0,0,0,0, 0,0,0,  0,5,0,0),   // R5 level up
        mk(5, 0,0, 0,0,0,0,0, 0,0,0,  0,0,0,0),   // R5 level gone
        mk(8, 0,0, 0,0,1,0,0, 0,0,0,  0,0,0,0),   // R8 enable
        mk(8, 0,0, 1,0,0,0,0, 0,0,0,  0,0,1,0),   // R8 retire
        mk(5, 0,0, 0,0,0,0,0, 0,0,0,  0,0,1,0),   // R5 nothing remembered
        mk(9, 0,2, 0,0,0,1,0, 0,0,0,  0,6,1,0),   // R9 disable same cycle
        mk(9, 0,2, 0,0,0,0,0, 0,2,0,  0,6,0,0),   // R9 masked
        mk(8, 0,2, 0,0,1,0,0, 0,0,0,  0,6,0,0),   // R8 enable
        mk(8, 0,2, 1,0,0,0,0, 0,0,0,  0,6,1,0),   // R8 holdoff
        mk(10,1,2, 0,0,0,0,0, 0,2,0,  1,6,1,1),   // R10 gie reads one
        mk(6, 0,2, 0,0,0,0,1, 0,0,0,  1,1,1,1),   // R6 flag beats level
        mk(4, 0,2, 0,0,0,0,0, 0,0,0,  0,6,0,0),   // R4 flag cleared
        mk(1, 1,2, 0,0,0,0,0, 1,1,62, 0,6,0,63),  // R1 disable src0, event
        mk(1, 0,2, 0,0,0,0,0, 0,0,0,  0,6,0,1),   // R1 flag set while off
        mk(1, 0,0, 0,0,0,0,0, 0,0,0,  0,0,0,1)    // R1 still pending
    };

    task automatic chk(input string rq, input string what, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp_v);
        end
    endtask

    task automatic idle_inputs();
        evt_i = '0; lvl_i = '0; reg_wr_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
        retire_i = 0; reti_i = 0; sei_i = 0; cli_i = 0; ack_i = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    initial begin
        string rq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NROWS; k++) begin
            @(negedge clk);
            evt_i = TBL[k][31:28]; lvl_i = TBL[k][27:26];
            retire_i = TBL[k][25]; reti_i = TBL[k][24]; sei_i = TBL[k][23];
            cli_i = TBL[k][22]; ack_i = TBL[k][21]; reg_wr_i = TBL[k][20];
            reg_addr_i = TBL[k][19:18]; reg_wdata_i = TBL[k][17:12];
            #1;
            rq = $sformatf("R%0d row%0d", TBL[k][35:32], k);
            chk(rq, "irq", int'(irq_o), int'(TBL[k][11]));
            chk(rq, "vec", int'(vec_o), int'(TBL[k][10:8]));
            chk(rq, "gie", int'(gie_o), int'(TBL[k][7]));
            chk(rq, "rdata", int'(reg_rdata_o), int'(TBL[k][6:1]));
        end

        // R9: global enable and disable in the same cycle stay masked
        @(negedge clk); idle_inputs(); sei_i = 1; cli_i = 1;
        @(negedge clk); idle_inputs(); #1;
        chk("R9", "gie after sei+cli", int'(gie_o), 0);

        // R11: reset mid-run clears flags, enables and global enable
        @(negedge clk); idle_inputs(); sei_i = 1;
        @(negedge clk); idle_inputs(); evt_i = 4'b0010;
        @(negedge clk); idle_inputs(); rst_n = 0; #1;
        reg_addr_i = 2'd0; #1;
        chk("R11", "flags in reset", int'(reg_rdata_o), 0);
        reg_addr_i = 2'd1; #1;
        chk("R11", "enables in reset", int'(reg_rdata_o), 0);
        chk("R11", "gie in reset", int'(gie_o), 0);
        chk("R11", "irq in reset", int'(irq_o), 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); #1;
        chk("R11", "vec after reset", int'(vec_o), 0);

        done = 1'b1;
        finish_run();
    end

endmodule